// File: doc/BRIEF.md
# Resistance-to-Frequency Measurement Counter

This block measures the frequency of an external RC oscillator whose timing resistor is switched among three paths: a reference resistor, a temperature sensor and a humidity sensor. A 16-bit counter does the measuring. Software picks a path and a mode, then pulses `start`. While the run is active the block drives a one-hot enable to the selected resistor path.

The block has two modes. In direct mode each rising edge of the oscillator adds one to the counter while a gate is open. The gate opens at `start`. It closes either on a software `stop` pulse or on a pulse from an interval timer. In period mode the block waits for a rising edge of the oscillator, then counts pulses of an internal reference tick until the next rising edge. At that point it raises a one-cycle completion interrupt. This mode suits oscillators too slow to give a useful count in a fixed window.

A full reading is taken in two runs: first the reference path, then a sensor path. Software compares the two counts; that arithmetic lies outside the block. The oscillator input is asynchronous and is synchronized inside. The result is read back four bits at a time through a nibble selector. The block carries no data stream. The readout is a plain select-and-read status path, so there is no valid/ready handshake and no back-pressure to manage.

Top module: `rfc_meter`

## Requirements
- R1: After reset, `busy`, `done`, `irq` and `ovf` are 0, `path_en` is 0 and every nibble of the result reads 0.
- R2: A `start` pulse clears the counter, `ovf` and `done`, even in the middle of a run. It also captures `mode`, `gate_src` and `path_sel`, so later changes to those inputs have no effect until the next `start`. `start` takes priority over every other event in the same cycle.
- R3: In direct mode (`mode`=0) the counter adds one for each rising edge of `osc_in`, detected through a two-flop synchronizer. The gate closes on `stop` when `gate_src`=0 and on `gate_tick` when `gate_src`=1. The closing source that is not selected is ignored. An edge seen in the closing cycle is still counted.
- R4: In period mode (`mode`=1) the block waits for a rising edge of `osc_in`, then counts `ref_tick` pulses until the next rising edge. A `ref_tick` in the cycle of either edge is not counted, so a constant-high `ref_tick` over an edge spacing of P cycles gives P-1.
- R5: `irq` is high for exactly one cycle, in the cycle after a period-mode run completes. It never rises for a direct-mode run.
- R6: `ovf` sets when the counter wraps from 0xFFFF to 0 and stays set until the next `start`.
- R7: The result latch loads only when a run completes. With `nib_sel`=k, `nib_out` shows latch bits 4k+3..4k. Oscillator activity while idle leaves the result unchanged.
- R8: While busy, `path_en` is one-hot: bit 0 for `path_sel`=0 (reference), bit 1 for 1 (temperature), bit 2 for 2 (humidity). `path_sel`=3 enables no path. `path_en` is 0 while idle.
- R9: `busy` is high from the cycle after `start` until completion. `done` sets at completion and clears on `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Oscillator input, asynchronous |
| ref_tick | input | 1 | Internal reference tick, one pulse per count (period mode) |
| gate_tick | input | 1 | Interval-timer gate end pulse (direct mode, `gate_src`=1) |
| start | input | 1 | Start pulse |
| stop | input | 1 | Software gate end pulse (direct mode, `gate_src`=0) |
| mode | input | 1 | 0 direct, 1 period |
| gate_src | input | 1 | 0 software stop, 1 interval timer |
| path_sel | input | 2 | 0 reference, 1 temperature, 2 humidity, 3 none |
| nib_sel | input | 2 | Result nibble select, 0 = least significant |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result valid since last start |
| irq | output | 1 | One-cycle period-mode completion pulse |
| ovf | output | 1 | Sticky counter wrap flag |
| nib_out | output | 4 | Selected result nibble |
| path_en | output | 3 | One-hot resistor path enable |

## Verification
The bench checks the counts at the edges of the gate:
- A design that dropped the edge arriving in the closing cycle, or counted a tick in the cycle of the opening edge, would be off by one against the P-1 rule.
- A period-mode run longer than 65536 ticks must leave a wrapped count with `ovf` set. A design with a non-sticky flag would lose it before the run ends.

The bench also covers the capture rules:
- A restart in the middle of a run must clear the count.
- A changed `mode` or `gate_src` during a run, or a pulse on the unselected closing source, must leave the run alone.
- A design that latched the result continuously would show oscillator activity after completion in `nib_out`.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } rfc_state_e;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_PERIOD = 1'b1
  } rfc_mode_e;

  localparam int unsigned NUM_PATHS = 3;
  localparam int unsigned PATH_SEL_W = 2;
endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rfc_ctrl.sv
module rfc_ctrl
  import rfc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  gate_tick_i,
  input  logic                  mode_i,
  input  logic                  gate_src_i,
  input  logic [PATH_SEL_W-1:0] path_sel_i,
  input  logic                  rise_i,
  input  logic                  ref_tick_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  irq_o,
  output logic                  inc_o,
  output logic                  fin_o,
  output logic [NUM_PATHS-1:0]  path_en_o
);
  rfc_state_e            state_q, state_d;
  rfc_mode_e             mode_q;
  logic                  src_q;
  logic [PATH_SEL_W-1:0] path_q;
  logic                  done_q, irq_q;
  logic                  closing;

  // Which event ends a direct-mode gate depends on the captured source.
  assign closing = src_q ? gate_tick_i : stop_i;

  always_comb begin
    inc_o   = 1'b0;
    fin_o   = 1'b0;
    state_d = state_q;
    if (start_i) begin
      state_d = (rfc_mode_e'(mode_i) == MODE_PERIOD) ? ST_ARM : ST_COUNT;
    end else begin
      case (state_q)
        ST_ARM: begin
          if (rise_i) state_d = ST_COUNT;
        end
        ST_COUNT: begin
          if (mode_q == MODE_PERIOD) begin
            inc_o = ref_tick_i & ~rise_i;
            fin_o = rise_i;
          end else begin
            inc_o = rise_i;
            fin_o = closing;
          end
          if (fin_o) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_DIRECT;
      src_q   <= 1'b0;
      path_q  <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= fin_o & (mode_q == MODE_PERIOD);
      if (start_i) begin
        mode_q <= rfc_mode_e'(mode_i);
        src_q  <= gate_src_i;
        path_q <= path_sel_i;
        done_q <= 1'b0;
      end else if (fin_o) begin
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign irq_o  = irq_q;

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    assign path_en_o[g] = busy_o && (path_q == PATH_SEL_W'(g));
  end

  AST_PATH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(path_en_o)); // R8
  AST_IRQ_FROM_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(state_q) == ST_COUNT && $past(mode_q) == MODE_PERIOD)); // R5
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R5
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && busy_o)); // R9
endmodule

// File: rtl/rfc_counter.sv
module rfc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             fin_i,
  output logic [CNT_W-1:0] latch_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q;

  assign cnt_d = inc_i ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      latch_o <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (inc_i && cnt_q == CNT_MAX) ovf_q <= 1'b1;
      if (fin_i) latch_o <= cnt_d;
    end
  end

  assign ovf_o = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_i) |=> ovf_o); // R6
  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> $stable(latch_o)); // R7
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && !ovf_o)); // R2
endmodule

// File: rtl/rfc_nibble_mux.sv
module rfc_nibble_mux #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [NIB_W-1:0]  nib_o
);
  localparam int unsigned NUM_NIB = DATA_W / NIB_W;

  logic [NIB_W-1:0] nibs [NUM_NIB];

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
    assign nibs[g] = data_i[g*NIB_W +: NIB_W];
  end

  always_comb begin
    nib_o = '0;
    for (int i = 0; i < NUM_NIB; i++) begin
      if (sel_i == SEL_W'(i)) nib_o = nibs[i];
    end
  end
endmodule

// File: rtl/rfc_meter.sv
module rfc_meter #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_NIB    = CNT_W / NIB_W,
  localparam int unsigned SEL_W      = (NUM_NIB > 1) ? $clog2(NUM_NIB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_in,
  input  logic             ref_tick,
  input  logic             gate_tick,
  input  logic             start,
  input  logic             stop,
  input  logic             mode,
  input  logic             gate_src,
  input  logic [1:0]       path_sel,
  input  logic [SEL_W-1:0] nib_sel,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             ovf,
  output logic [NIB_W-1:0] nib_out,
  output logic [2:0]       path_en
);
  logic             rise;
  logic             inc, fin;
  logic [CNT_W-1:0] result;

  rfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(osc_in), .rise_o(rise)
  );

  rfc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
    .gate_tick_i(gate_tick), .mode_i(mode), .gate_src_i(gate_src),
    .path_sel_i(path_sel), .rise_i(rise), .ref_tick_i(ref_tick),
    .busy_o(busy), .done_o(done), .irq_o(irq), .inc_o(inc), .fin_o(fin),
    .path_en_o(path_en)
  );

  rfc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(start), .inc_i(inc), .fin_i(fin),
    .latch_o(result), .ovf_o(ovf)
  );

  rfc_nibble_mux #(.DATA_W(CNT_W), .NIB_W(NIB_W), .SEL_W(SEL_W)) u_mux (
    .data_i(result), .sel_i(nib_sel), .nib_o(nib_out)
  );

  AST_IDLE_NO_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (path_en == '0)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy); // R9
endmodule

// File: tb/tb_rfc_meter.sv
module tb_rfc_meter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_in = 0, ref_tick = 0, gate_tick = 0, start = 0, stop = 0;
  logic mode = 0, gate_src = 0;
  logic [1:0] path_sel = 0, nib_sel = 0;
  logic busy, done, irq, ovf;
  logic [3:0] nib_out;
  logic [2:0] path_en;

  int checks = 0, errors = 0;

  rfc_meter dut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ref_tick(ref_tick),
    .gate_tick(gate_tick), .start(start), .stop(stop), .mode(mode),
    .gate_src(gate_src), .path_sel(path_sel), .nib_sel(nib_sel),
    .busy(busy), .done(done), .irq(irq), .ovf(ovf), .nib_out(nib_out),
    .path_en(path_en)
  );

  always #2 clk = ~clk;

  // Behavioural reference model
  int m_state = 0, m_cnt = 0, m_latch = 0, m_mode = 0, m_src = 0, m_path = 0;
  bit m_ovf = 0, m_done = 0, m_irq = 0;
  bit hist[$] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    bit e, inc, fin;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_latch = 0; m_ovf = 0; m_done = 0; m_irq = 0;
      m_mode = 0; m_src = 0; m_path = 0;
      hist = '{0, 0, 0, 0};
    end else begin
      hist.push_front(osc_in);
      e = hist[2] && !hist[3];
      void'(hist.pop_back());
      m_irq = 0;
      if (start) begin
        m_cnt = 0; m_ovf = 0; m_done = 0;
        m_mode = mode; m_src = gate_src; m_path = path_sel;
        m_state = mode ? 1 : 2;
      end else if (m_state == 1) begin
        if (e) m_state = 2;
      end else if (m_state == 2) begin
        inc = m_mode ? (ref_tick && !e) : e;
        fin = m_mode ? e : (m_src ? gate_tick : stop);
        if (inc) begin
          if (m_cnt == 65535) m_ovf = 1;
          m_cnt = (m_cnt + 1) % 65536;
        end
        if (fin) begin
          m_latch = m_cnt; m_done = 1; m_irq = bit'(m_mode); m_state = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    int exp_path, exp_nib;
    exp_path = (m_state != 0 && m_path < 3) ? (1 << m_path) : 0;
    exp_nib  = (m_latch >> (4 * nib_sel)) & 15;
    chk(busy == (m_state != 0), "R9 busy", busy, m_state != 0);
    chk(done == m_done, "R9 done", done, m_done);
    chk(irq == m_irq, "R5 irq", irq, m_irq);
    chk(ovf == m_ovf, "R6 ovf", ovf, m_ovf);
    chk(path_en == 3'(exp_path), "R8 path_en", path_en, exp_path);
    chk(nib_out == 4'(exp_nib), "R7 nib_out", nib_out, exp_nib);
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_start(input bit md, input bit src, input logic [1:0] ps);
    mode = md; gate_src = src; path_sel = ps; start = 1; tick(); start = 0;
  endtask

  task automatic osc_pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      osc_in = 1; tick(hi); osc_in = 0; tick(lo);
    end
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) tick();
  endtask

  task automatic read_result(output int val);
    val = 0;
    for (int k = 0; k < 4; k++) begin
      nib_sel = 2'(k); @(negedge clk);
      val = val | (int'(nib_out) << (4 * k));
      tick();
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    tick(3);
    rst_n = 1; tick();
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !irq && !ovf && path_en == 0, "R1 reset flags", {busy, done, irq, ovf}, 0);
    read_result(v);
    chk(v == 0, "R1 reset result", v, 0);

    // R3 direct, software gate, reference path; R8 path bit 0
    pulse_start(0, 0, 2'd0);
    @(negedge clk); chk(path_en == 3'b001, "R8 reference path", path_en, 1);
    tick();
    gate_tick = 1; tick(); gate_tick = 0;              // unselected source, ignored
    osc_pulses(10, 3, 3);
    tick(4); stop = 1; tick(); stop = 0;
    @(negedge clk); chk(done && !busy, "R9 done after stop", done, 1);
    read_result(v);
    chk(v == 10, "R3 direct software count", v, 10);
    // R7 idle oscillator activity leaves result
    osc_pulses(5, 2, 2); tick(4);
    read_result(v);
    chk(v == 10, "R7 frozen latch", v, 10);

    // R3 direct, timer gate, temperature; stop ignored; edge in closing cycle counted
    pulse_start(0, 1, 2'd1);
    @(negedge clk); chk(path_en == 3'b010, "R8 temperature path", path_en, 2);
    osc_pulses(5, 2, 2);
    tick(4); stop = 1; tick(); stop = 0;
    @(negedge clk); chk(busy, "R3 stop ignored in timer gate", busy, 1);
    osc_pulses(3, 2, 2);
    osc_in = 1; tick(2);   // rise seen by the synchronizer in the closing cycle
    gate_tick = 1; tick(); gate_tick = 0; osc_in = 0; tick(4);
    read_result(v);
    chk(v == 9, "R3 timer gate count incl closing-cycle edge", v, 9);

    // R4/R5 period mode, humidity path, ref_tick always high, spacing 40
    ref_tick = 1;
    pulse_start(1, 0, 2'd2);
    @(negedge clk); chk(path_en == 3'b100, "R8 humidity path", path_en, 4);
    tick(3);
    osc_pulses(2, 20, 20);
    wait_done(20);
    read_result(v);
    chk(v == 39, "R4 period count spacing 40", v, 39);
    chk(!ovf, "R6 no overflow", ovf, 0);

    // R2 restart mid-run, changed inputs ignored until next start
    pulse_start(0, 0, 2'd3);
    @(negedge clk); chk(path_en == 3'b000 && busy, "R8 code 3 no path", path_en, 0);
    osc_pulses(4, 2, 2);
    pulse_start(0, 0, 2'd3);                           // restart clears count
    mode = 1; gate_src = 1; path_sel = 2'd0;
    osc_pulses(6, 2, 2);
    gate_tick = 1; tick(); gate_tick = 0;
    tick(4);
    @(negedge clk); chk(busy && path_en == 0, "R2 captured settings held", busy, 1);
    stop = 1; tick(); stop = 0; tick(2);
    read_result(v);
    chk(v == 6, "R2 restart clears count", v, 6);

    // R6 overflow in period mode: spacing 70000 -> 69999 mod 65536 = 4463
    pulse_start(1, 0, 2'd0);
    tick(3);
    osc_pulses(1, 1, 69999);
    osc_in = 1; tick(2); osc_in = 0;
    wait_done(20);
    @(negedge clk); chk(ovf, "R6 overflow set", ovf, 1);
    read_result(v);
    chk(v == 4463, "R6 wrapped count", v, 4463);
    nib_sel = 2'd0; @(negedge clk); chk(nib_out == 4'hF, "R7 nibble 0", nib_out, 15);
    nib_sel = 2'd3; @(negedge clk); chk(nib_out == 4'h1, "R7 nibble 3", nib_out, 1);
    tick(5);
    @(negedge clk); chk(ovf, "R6 overflow sticky", ovf, 1);
    pulse_start(0, 0, 2'd0);
    @(negedge clk); chk(!ovf && !done, "R2 start clears ovf", ovf, 0);
    tick(2);
    finish_run();
  end
endmodule